// File: doc/BRIEF.md
# Conversion Result Latch and Byte Output Port

This block is the digital back end of a dual-slope analog-to-digital converter. The conversion sequencer marks the start of the input-integrate phase with one strobe. When the binary count is final, it sends a second strobe. The block then captures the count, the sign flag and the over-range flag into an output latch. A `status` output goes high during the integrate phase and falls half a clock period after the latch is written. While `status` is low the latched word is guaranteed to be stable, so `status` can serve as a data-valid flag or an interrupt source.

The latched word is presented as 8-bit lanes, and each lane has its own output enable that stands in for a three-state driver. The 16-bit variant uses three lanes and the 14-bit variant uses two. In direct mode, a lane is enabled only while `chip_en` and that lane's bit of `byte_en` are both high. A rising edge on `mode_in` starts a handshake burst. The burst sends the lanes one at a time to a serial-style receiver, moving on only when the receiver acknowledges. After the burst the block returns to direct mode. If `mode_in` is held high, a burst also follows every conversion.

Top module: `adc_result_port`

## Requirements
- R1: A synchronous reset `rst` clears the latched word to zero, ends any burst, and drives `status` low (`status` follows at the falling clock edge).
- R2: `status` goes high half a clock period after the rising edge that samples `integ_start` high.
- R3: A `latch_stb` sampled while the integrate phase is open writes the new word into the latch at that rising edge. It also closes the phase, and `status` falls half a clock period later.
- R4: A `latch_stb` sampled while the integrate phase is closed is ignored, so the latched word never changes while `status` is low.
- R5: The lane layout is as follows. The top lane carries the sign in bit 7 and over-range in bit 6. The data count fills the word from bit 0 upward, lane 0 holding count bits 7..0. In the 16-bit variant, lane 2 is {sign, over-range, 6'b0}, lane 1 is count[15:8] and lane 0 is count[7:0].
- R6: When no burst is active, `lane_oe[i]` equals `chip_en & byte_en[i]`, and `lane_data` shows the latched word.
- R7: A rising edge on `mode_in` while idle starts a burst at that clock edge. The burst sends a snapshot of the latched word, and the direct enables have no effect during it. When the burst ends, direct mode resumes.
- R8: While `mode_in` stays high, each accepted `latch_stb` starts a burst carrying the newly latched word.
- R9: A burst sends the top lane first and then descends to lane 0. Exactly one lane is enabled and `hs_send` is high throughout the burst. Each byte is held unchanged until `hs_ack` is sampled high, and an acknowledge on lane 0 ends the burst.
- R10: The 14-bit variant sends two bytes per burst: lane 1 is {sign, over-range, count[13:8]} and lane 0 is count[7:0].
- R11: Triggers arriving during a burst are ignored. A conversion latched during a burst does not alter the bytes being sent, but it does appear on the lanes in direct mode afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; `status` is registered on the falling edge, all else on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| integ_start | input | 1 | Start of input-integrate phase |
| latch_stb | input | 1 | Conversion result is final; latch it |
| res_count | input | DATA_BITS | Binary conversion count |
| res_neg | input | 1 | Sign flag of the result |
| res_ovr | input | 1 | Over-range flag of the result |
| mode_in | input | 1 | Low: direct mode; rising edge: one burst; held high: burst after each conversion |
| chip_en | input | 1 | Direct-mode chip enable |
| byte_en | input | LANES | Direct-mode per-lane enables, bit i selects lane i |
| hs_ack | input | 1 | Receiver acknowledge of the byte on the bus |
| status | output | 1 | High from integrate start until half a clock after the latch write |
| hs_send | output | 1 | High while a handshake burst is presenting a byte |
| lane_oe | output | LANES | Per-lane output enable (three-state model) |
| lane_data | output | 8*LANES | Lane contents, lane i in bits 8i+7..8i |

## Verification
`status` changes half a cycle after the rising edge that samples its cause. The bench therefore drives a strobe on a falling edge and reads `status` a quarter period after the next rising edge, where it must still be old. It reads again three quarters after that edge, where it must be new. A latch write is visible on `lane_data` in the same quarter-period sample, and the lane enables in direct mode are combinational and are read one nanosecond after the inputs change. In a burst the first byte appears at the rising edge that samples the trigger, and each later byte appears at the edge that samples `hs_ack`. The scoreboard monitor reads the bus on falling edges, acknowledges after a programmable delay, and checks in every waiting cycle that the byte and its enable stay put.

// File: rtl/adc_port_pkg.sv
`timescale 1ns/1ps
package adc_port_pkg;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_SEND = 1'b1
    } seq_state_e;

    // Number of 8-bit lanes needed for sign, over-range and the count.
    function automatic int lanes_for(input int data_bits);
        return (data_bits + 2 + 7) / 8;
    endfunction

endpackage

// File: rtl/adc_result_store.sv
`timescale 1ns/1ps
module adc_result_store #(
    parameter int DATA_BITS = 16,
    parameter int LANES     = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   integ_start,
    input  logic                   latch_stb,
    input  logic [DATA_BITS-1:0]   res_count,
    input  logic                   res_neg,
    input  logic                   res_ovr,
    output logic                   phase_open,
    output logic                   load_evt,
    output logic [8*LANES-1:0]     word_next,
    output logic [8*LANES-1:0]     word
);
    localparam int WORD_W = 8 * LANES;

    typedef struct packed {
        logic              open;
        logic [WORD_W-1:0] word;
    } store_t;

    store_t st_d, st_q;
    logic [WORD_W-1:0] packed_res;

    always_comb begin
        packed_res                  = '0;
        packed_res[DATA_BITS-1:0]   = res_count;
        packed_res[WORD_W-1]        = res_neg;
        packed_res[WORD_W-2]        = res_ovr;

        load_evt = latch_stb & st_q.open;

        st_d = st_q;
        if (load_evt) begin
            st_d.word = packed_res;
            st_d.open = 1'b0;
        end else if (integ_start) begin
            st_d.open = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign phase_open = st_q.open;
    assign word       = st_q.word;
    assign word_next  = st_d.word;

endmodule

// File: rtl/adc_status_halfclk.sv
`timescale 1ns/1ps
module adc_status_halfclk (
    input  logic clk,
    input  logic rst,
    input  logic phase_open,
    output logic status
);
    logic status_d, status_q;

    always_comb begin
        status_d = rst ? 1'b0 : phase_open;
    end

    // Falling-edge register: every change lands half a period after its cause.
    always_ff @(negedge clk) begin
        status_q <= status_d;
    end

    assign status = status_q;

endmodule

// File: rtl/adc_burst_seq.sv
`timescale 1ns/1ps
module adc_burst_seq #(
    parameter int LANES = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 mode_in,
    input  logic                 load_evt,
    input  logic [8*LANES-1:0]   word_next,
    input  logic [8*LANES-1:0]   word,
    input  logic                 chip_en,
    input  logic [LANES-1:0]     byte_en,
    input  logic                 hs_ack,
    output logic                 hs_send,
    output logic [LANES-1:0]     lane_oe,
    output logic [8*LANES-1:0]   lane_data
);
    import adc_port_pkg::*;

    localparam int WORD_W = 8 * LANES;
    localparam int IDX_W  = (LANES > 1) ? $clog2(LANES) : 1;
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(LANES - 1);

    typedef struct packed {
        seq_state_e        state;
        logic [IDX_W-1:0]  idx;
        logic              mode_prev;
        logic [WORD_W-1:0] snap;
    } seq_t;

    seq_t sq_d, sq_q;
    logic trig;

    always_comb begin
        sq_d           = sq_q;
        sq_d.mode_prev = mode_in;
        trig           = mode_in & (~sq_q.mode_prev | load_evt);

        case (sq_q.state)
            SEQ_IDLE: begin
                if (trig) begin
                    sq_d.state = SEQ_SEND;
                    sq_d.idx   = TOP_IDX;
                    sq_d.snap  = word_next;
                end
            end
            SEQ_SEND: begin
                if (hs_ack) begin
                    if (sq_q.idx == '0) sq_d.state = SEQ_IDLE;
                    else                sq_d.idx   = sq_q.idx - 1'b1;
                end
            end
            default: sq_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) sq_q <= '0;
        else     sq_q <= sq_d;
    end

    assign hs_send   = (sq_q.state == SEQ_SEND);
    assign lane_data = hs_send ? sq_q.snap : word;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_oe[i] = hs_send ? (sq_q.idx == IDX_W'(i))
                                    : (chip_en & byte_en[i]);
    end

endmodule

// File: rtl/adc_result_port.sv
`timescale 1ns/1ps
module adc_result_port #(
    parameter  int DATA_BITS = 16,
    localparam int LANES     = adc_port_pkg::lanes_for(DATA_BITS),
    localparam int WORD_W    = 8 * LANES
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  integ_start,
    input  logic                  latch_stb,
    input  logic [DATA_BITS-1:0]  res_count,
    input  logic                  res_neg,
    input  logic                  res_ovr,
    input  logic                  mode_in,
    input  logic                  chip_en,
    input  logic [LANES-1:0]      byte_en,
    input  logic                  hs_ack,
    output logic                  status,
    output logic                  hs_send,
    output logic [LANES-1:0]      lane_oe,
    output logic [WORD_W-1:0]     lane_data
);
    logic              phase_open;
    logic              load_evt;
    logic [WORD_W-1:0] word_next;
    logic [WORD_W-1:0] latched_word;

    adc_result_store #(
        .DATA_BITS (DATA_BITS),
        .LANES     (LANES)
    ) u_store (
        .clk         (clk),
        .rst         (rst),
        .integ_start (integ_start),
        .latch_stb   (latch_stb),
        .res_count   (res_count),
        .res_neg     (res_neg),
        .res_ovr     (res_ovr),
        .phase_open  (phase_open),
        .load_evt    (load_evt),
        .word_next   (word_next),
        .word        (latched_word)
    );

    adc_status_halfclk u_status (
        .clk        (clk),
        .rst        (rst),
        .phase_open (phase_open),
        .status     (status)
    );

    adc_burst_seq #(
        .LANES (LANES)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .mode_in   (mode_in),
        .load_evt  (load_evt),
        .word_next (word_next),
        .word      (latched_word),
        .chip_en   (chip_en),
        .byte_en   (byte_en),
        .hs_ack    (hs_ack),
        .hs_send   (hs_send),
        .lane_oe   (lane_oe),
        .lane_data (lane_data)
    );

endmodule

// File: rtl/adc_result_port_chk.sv
`timescale 1ns/1ps
module adc_result_port_chk #(
    parameter int LANES = 3
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 status,
    input logic                 hs_send,
    input logic                 hs_ack,
    input logic                 chip_en,
    input logic [LANES-1:0]     lane_oe,
    input logic [8*LANES-1:0]   lane_data,
    input logic [8*LANES-1:0]   latched
);
    // R4
    latch_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !status |=> $stable(latched));

    // R3
    status_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(latched) |-> !status);

    // R6
    direct_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!hs_send && !chip_en) |-> (lane_oe == '0));

    // R9
    one_lane_chk: assert property (@(posedge clk) disable iff (rst)
        hs_send |-> ($countones(lane_oe) == 1));

    // R9
    byte_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (hs_send && !hs_ack) |=> (hs_send && $stable(lane_oe) && $stable(lane_data)));

    // R9
    last_byte_chk: assert property (@(posedge clk) disable iff (rst)
        (hs_send && hs_ack && lane_oe[0]) |=> !hs_send);

endmodule

bind adc_result_port adc_result_port_chk #(.LANES(LANES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .status    (status),
    .hs_send   (hs_send),
    .hs_ack    (hs_ack),
    .chip_en   (chip_en),
    .lane_oe   (lane_oe),
    .lane_data (lane_data),
    .latched   (latched_word)
);

// File: tb/adc_result_port_test.sv
`timescale 1ns/1ps
module adc_result_port_test;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst = 1'b1;
    logic        integ_start = 1'b0, latch_stb = 1'b0;
    logic [15:0] res_count = '0;
    logic        res_neg = 1'b0, res_ovr = 1'b0;
    logic        mode_in = 1'b0, chip_en = 1'b0, hs_ack = 1'b0;
    logic [2:0]  byte_en = '0;
    logic        status, hs_send;
    logic [2:0]  lane_oe;
    logic [23:0] lane_data;

    logic        mode_n = 1'b0, ack_n = 1'b0;
    logic        status_n, hs_send_n;
    logic [1:0]  oe_n;
    logic [15:0] data_n;

    adc_result_port #(.DATA_BITS(16)) uut (
        .clk(clk), .rst(rst), .integ_start(integ_start), .latch_stb(latch_stb),
        .res_count(res_count), .res_neg(res_neg), .res_ovr(res_ovr),
        .mode_in(mode_in), .chip_en(chip_en), .byte_en(byte_en), .hs_ack(hs_ack),
        .status(status), .hs_send(hs_send), .lane_oe(lane_oe), .lane_data(lane_data)
    );

    adc_result_port #(.DATA_BITS(14)) uut_narrow (
        .clk(clk), .rst(rst), .integ_start(integ_start), .latch_stb(latch_stb),
        .res_count(res_count[13:0]), .res_neg(res_neg), .res_ovr(res_ovr),
        .mode_in(mode_n), .chip_en(chip_en), .byte_en(byte_en[1:0]), .hs_ack(ack_n),
        .status(status_n), .hs_send(hs_send_n), .lane_oe(oe_n), .lane_data(data_n)
    );

    int checks = 0;
    int errors = 0;
    int ack_delay = 0;
    logic [9:0] exp_q[$];   // {lane, byte}

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] wide_word(input logic [15:0] c, input logic p, input logic o);
        return {p, o, 6'b0, c};
    endfunction

    function automatic logic [15:0] narrow_word(input logic [15:0] c, input logic p, input logic o);
        return {p, o, c[13:0]};
    endfunction

    // Driver side of the scoreboard: expected bytes, top lane first.
    task automatic push_burst(input logic [23:0] w);
        for (int i = 2; i >= 0; i--) exp_q.push_back({2'(i), w[8*i +: 8]});
    endtask

    task automatic convert(input logic [15:0] c, input logic p, input logic o);
        @(negedge clk); integ_start = 1'b1;
        @(posedge clk); #1 integ_start = 1'b0;
        repeat (2) @(negedge clk);
        res_count = c; res_neg = p; res_ovr = o; latch_stb = 1'b1;
        @(posedge clk); #1 latch_stb = 1'b0;
    endtask

    task automatic wait_idle();
        while (exp_q.size() != 0 || hs_send) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor side: receiver that checks each byte and acknowledges.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && hs_send && !hs_ack) begin
                logic [9:0]  e;
                logic [2:0]  oe0;
                logic [23:0] d0;
                if (exp_q.size() == 0) begin
                    chk("R11 byte sent with no burst expected", {29'b0, lane_oe}, 32'h0);
                end else begin
                    e = exp_q.pop_front();
                    chk("R9 lane order", {29'b0, lane_oe}, 32'(1) << e[9:8]);
                    chk("R5 lane byte value", {24'b0, lane_data[8*e[9:8] +: 8]}, {24'b0, e[7:0]});
                end
                oe0 = lane_oe;
                d0  = lane_data;
                for (int k = 0; k < ack_delay; k++) begin
                    @(negedge clk);
                    chk("R9 lane held until ack", {29'b0, lane_oe}, {29'b0, oe0});
                    chk("R9 byte held until ack", {8'b0, lane_data}, {8'b0, d0});
                end
                hs_ack = 1'b1;
                @(negedge clk);
                hs_ack = 1'b0;
            end
        end
    end

    initial begin
        #(20 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    logic [23:0] w1, w5;

    initial begin
        w1 = wide_word(16'hA5C3, 1'b1, 1'b1);
        w5 = wide_word(16'h3E07, 1'b0, 1'b1);

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk); #2;
        chk("R1 status after reset", {31'b0, status}, 32'h0);
        chk("R1 no burst after reset", {31'b0, hs_send}, 32'h0);
        chk("R1 latched word cleared", {8'b0, lane_data}, 32'h0);

        // R2: status rises half a clock after the sampling edge
        @(negedge clk); integ_start = 1'b1;
        @(posedge clk); #1 integ_start = 1'b0;
        #4  chk("R2 status not yet high", {31'b0, status}, 32'h0);
        #10 chk("R2 status high half clock later", {31'b0, status}, 32'h1);

        // R3: latch write and delayed status fall
        @(negedge clk);
        res_count = 16'hA5C3; res_neg = 1'b1; res_ovr = 1'b1; latch_stb = 1'b1;
        @(posedge clk); #1 latch_stb = 1'b0;
        #4  chk("R3 word written at edge", {8'b0, lane_data}, {8'b0, w1});
        chk("R3 status still high at write", {31'b0, status}, 32'h1);
        #10 chk("R3 status low half clock later", {31'b0, status}, 32'h0);

        // R4: strobe with closed phase is ignored
        @(negedge clk);
        res_count = 16'h1234; res_neg = 1'b0; res_ovr = 1'b0; latch_stb = 1'b1;
        @(posedge clk); #1 latch_stb = 1'b0;
        @(negedge clk); #2;
        chk("R4 word unchanged while status low", {8'b0, lane_data}, {8'b0, w1});
        chk("R4 status stays low", {31'b0, status}, 32'h0);

        // R6: direct mode enables
        chip_en = 1'b0; byte_en = 3'b111; #1;
        chk("R6 no lane without chip enable", {29'b0, lane_oe}, 32'h0);
        for (int i = 0; i < 3; i++) begin
            chip_en = 1'b1; byte_en = 3'(1 << i); #1;
            chk("R6 single lane enabled", {29'b0, lane_oe}, 32'(1) << i);
            chk("R5 direct lane byte", {24'b0, lane_data[8*i +: 8]}, {24'b0, w1[8*i +: 8]});
        end

        // R7: one burst on a mode pulse, direct enables overridden
        byte_en = 3'b111; ack_delay = 1;
        push_burst(w1);
        @(negedge clk); mode_in = 1'b1;
        @(negedge clk); mode_in = 1'b0;
        chk("R7 burst started by pulse", {31'b0, hs_send}, 32'h1);
        wait_idle();
        chk("R7 direct mode restored", {29'b0, lane_oe}, 32'h7);

        // R8: held mode bursts on its edge and after each conversion
        ack_delay = 2;
        push_burst(w1);
        @(negedge clk); mode_in = 1'b1;
        wait_idle();
        push_burst(wide_word(16'h00FF, 1'b0, 1'b0));
        convert(16'h00FF, 1'b0, 1'b0);
        #4 chk("R8 burst after conversion", {31'b0, hs_send}, 32'h1);
        wait_idle();
        ack_delay = 0;
        push_burst(wide_word(16'hFF00, 1'b1, 1'b0));
        convert(16'hFF00, 1'b1, 1'b0);
        wait_idle();

        // R11: conversion during a burst neither disturbs it nor starts another
        ack_delay = 4;
        push_burst(wide_word(16'h8001, 1'b0, 1'b0));
        convert(16'h8001, 1'b0, 1'b0);
        convert(16'h3E07, 1'b0, 1'b1);
        wait_idle();
        repeat (3) @(negedge clk);
        chk("R11 no second burst", {31'b0, hs_send}, 32'h0);
        chk("R11 new word visible in direct mode", {8'b0, lane_data}, {8'b0, w5});
        mode_in = 1'b0;

        // R10: narrow variant, two bytes
        @(negedge clk); mode_n = 1'b1;
        @(negedge clk); mode_n = 1'b0;
        chk("R10 narrow burst active", {31'b0, hs_send_n}, 32'h1);
        chk("R10 narrow top lane first", {30'b0, oe_n}, 32'h2);
        chk("R10 narrow top byte", {24'b0, data_n[15:8]},
            {24'b0, narrow_word(16'h3E07, 1'b0, 1'b1)}[15:8]);
        ack_n = 1'b1;
        @(negedge clk); ack_n = 1'b0;
        chk("R10 narrow low lane second", {30'b0, oe_n}, 32'h1);
        chk("R10 narrow low byte", {24'b0, data_n[7:0]},
            {24'b0, narrow_word(16'h3E07, 1'b0, 1'b1)}[7:0]);
        ack_n = 1'b1;
        @(negedge clk); ack_n = 1'b0;
        chk("R10 narrow burst ends after two bytes", {31'b0, hs_send_n}, 32'h0);

        // R1: reset mid-run clears latch and status
        convert(16'h7777, 1'b1, 1'b0);
        @(negedge clk); integ_start = 1'b1;
        @(posedge clk); #1 integ_start = 1'b0;
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); #2;
        chk("R1 reset drives status low", {31'b0, status}, 32'h0);
        chk("R1 reset clears word", {8'b0, lane_data}, 32'h0);
        @(posedge clk); #1 rst = 1'b0;

        repeat (2) @(negedge clk);
        chk("R9 scoreboard drained", exp_q.size(), 32'h0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule